// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps track of how reliable a CAN node has been on the bus and decides how far the node may take part in bus traffic. It keeps a transmit error count and a receive error count, both fed by single-cycle event pulses from the protocol engine. These pulses report a transmit error, a receive error, a good transmission and a good reception. The larger of the two counts picks one of three standings: error-active, error-passive or bus-off.

The standing drives the protocol engine directly. It picks the polarity of the error flag to send: six dominant bits while error-active, six recessive bits otherwise, each followed by the usual eight-bit recessive delimiter. It removes the transmit enable while bus-off. It also raises a suspend window of a set number of bit times once the intermission that follows a frame sent while error-passive has ended. Leaving bus-off takes a set number of reports of eleven recessive bits in a row. After that, both counts restart from zero.

Top module: `can_fault_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both counts are 0, state_o is 2'b00 (error-active), flag_dominant_o and tx_en_o are 1, and suspend_o is 0.
- R2: Outside bus-off, a tx_err_i pulse adds 8 to the transmit count and a tx_ok_i pulse subtracts 1. When both arrive together the net change is +7. The count never goes below 0.
- R3: Outside bus-off, rx_err_i adds 1 to the receive count and rx_ok_i subtracts 1, with the net change applied at once. The count stays within 0 to 255.
- R4: state_o is 2'b00 while both counts are below 128. It is 2'b01 (error-passive) when the larger count is from 128 to 255.
- R5: state_o becomes 2'b10 (bus-off) when the transmit count reaches 256 or more. The receive count alone never causes bus-off.
- R6: flag_dominant_o is 1 (send an active flag of dominant bits) only in error-active. It is 0 in the other two states.
- R7: While bus-off, tx_en_o is 0, suspend_o is 0, and every error or success pulse is ignored: both counts hold.
- R8: While bus-off, the 128th recessive_run_i pulse returns the node to error-active with both counts cleared. Before that pulse the node stays bus-off.
- R9: A tx_ok_i pulse while error-passive arms a suspend. At the next ifs_end_i pulse, suspend_o rises and stays high until 8 bit_tick_i pulses have been counted.
- R10: Every output reflects an input pulse from the clock edge that samples it. The latency is one cycle and there is no further pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_err_i | input | 1 | Transmit error detected (pulse) |
| rx_err_i | input | 1 | Receive error detected (pulse) |
| tx_ok_i | input | 1 | Frame transmitted successfully (pulse) |
| rx_ok_i | input | 1 | Frame received successfully (pulse) |
| recessive_run_i | input | 1 | Eleven consecutive recessive bits seen (pulse) |
| ifs_end_i | input | 1 | Intermission has ended (pulse) |
| bit_tick_i | input | 1 | One nominal bit time elapsed (pulse) |
| state_o | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |
| flag_dominant_o | output | 1 | 1: send dominant error flag, 0: recessive |
| tx_en_o | output | 1 | Node may drive the bus |
| suspend_o | output | 1 | Suspend-transmission window in progress |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 8 | Receive error count |

## Verification
A wrong count shows up on tec_o or rec_o on the cycle after the offending pulse. It then shows on state_o and flag_dominant_o when a threshold is crossed, and these can disagree with the counts from that same cycle. A recovery counter that is off by one releases bus-off one recessive run early or late, and tx_en_o shows this on the following cycle. A suspend timer fault changes the length of the suspend_o window in bit ticks, which the per-cycle reference model catches on the first tick that differs.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  // transmit count step: error adds inc, success takes one, floor at zero
  function automatic int fc_tec_next(int cur, logic err, logic ok, int inc);
    int t;
    t = cur + (err ? inc : 0) - (ok ? 1 : 0);
    if (t < 0) t = 0;
    return t;
  endfunction

  // receive count step: net change applied, clamped to [0, ceil]
  function automatic int fc_rec_next(int cur, logic err, logic ok, int ceil);
    int t;
    t = cur + (err ? 1 : 0) - (ok ? 1 : 0);
    if (t < 0) t = 0;
    if (t > ceil) t = ceil;
    return t;
  endfunction

  function automatic fc_state_e fc_classify(int tec, int rec, int passive_at, int busoff_at);
    int worst;
    worst = (tec > rec) ? tec : rec;
    if (tec >= busoff_at) return FC_BUSOFF;
    if (worst >= passive_at) return FC_PASSIVE;
    return FC_ACTIVE;
  endfunction

endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters
  import can_fc_pkg::*;
#(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int TX_ERR_INC = 8,
  parameter int REC_MAX    = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             clear,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  output logic [TEC_W-1:0] tec_q,
  output logic [REC_W-1:0] rec_q
);

  logic [TEC_W-1:0] tec_d;
  logic [REC_W-1:0] rec_d;

  always_comb begin
    tec_d = tec_q;
    rec_d = rec_q;
    if (clear) begin
      tec_d = '0;
      rec_d = '0;
    end else if (!freeze) begin
      tec_d = TEC_W'(fc_tec_next(int'(tec_q), tx_err, tx_ok, TX_ERR_INC));
      rec_d = REC_W'(fc_rec_next(int'(rec_q), rx_err, rx_ok, REC_MAX));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  assert_tx_err_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !clear && tx_err && !tx_ok) |=> (int'(tec_q) == int'($past(tec_q)) + TX_ERR_INC));

  assert_rx_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !clear && rx_ok && !rx_err && rec_q == '0) |=> (rec_q == '0));

  assert_frozen_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clear) |=> ($stable(tec_q) && $stable(rec_q)));

endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
  parameter int RECOVER_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_busoff,
  input  logic run_i,
  output logic clear_o
);

  localparam int RUN_W = $clog2(RECOVER_RUNS + 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RECOVER_RUNS - 1);

  logic [RUN_W-1:0] run_q;

  assign clear_o = in_busoff && run_i && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_busoff) begin
      run_q <= '0;
    end else if (run_i) begin
      run_q <= clear_o ? '0 : run_q + 1'b1;
    end
  end

  assert_count_in_busoff_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_busoff |=> (run_q == '0));

endmodule

// File: rtl/fc_suspend.sv
module fc_suspend #(
  parameter int SUSPEND_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_busoff,
  input  logic arm,
  input  logic ifs_end,
  input  logic bit_tick,
  output logic suspend_o
);

  localparam int CNT_W = $clog2(SUSPEND_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SUSPEND_BITS - 1);

  logic             pending_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start     = !active_q && pending_q && ifs_end;
  assign suspend_o = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n || in_busoff) begin
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (arm)        pending_q <= 1'b1;
      else if (start) pending_q <= 1'b0;

      if (active_q) begin
        if (bit_tick) begin
          if (cnt_q == LAST) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end
  end

  assert_suspend_starts_on_ifs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_o) |-> $past(ifs_end));

  assert_no_suspend_busoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_busoff |=> !suspend_o);

endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard
  import can_fc_pkg::*;
#(
  parameter int PASSIVE_AT   = 128,
  parameter int BUSOFF_AT    = 256,
  parameter int TX_ERR_INC   = 8,
  parameter int RECOVER_RUNS = 128,
  parameter int SUSPEND_BITS = 8,
  localparam int TEC_W = $clog2(BUSOFF_AT + TX_ERR_INC),
  localparam int REC_W = $clog2(BUSOFF_AT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             recessive_run_i,
  input  logic             ifs_end_i,
  input  logic             bit_tick_i,
  output logic [1:0]       state_o,
  output logic             flag_dominant_o,
  output logic             tx_en_o,
  output logic             suspend_o,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o
);

  localparam int REC_MAX = BUSOFF_AT - 1;

  fc_state_e        st;
  logic             in_busoff;
  logic             recover_clr;
  logic             suspend_arm;
  logic [TEC_W-1:0] tec_q;
  logic [REC_W-1:0] rec_q;

  assign st          = fc_classify(int'(tec_q), int'(rec_q), PASSIVE_AT, BUSOFF_AT);
  assign in_busoff   = (st == FC_BUSOFF);
  assign suspend_arm = tx_ok_i && (st == FC_PASSIVE);

  fc_err_counters #(
    .TEC_W(TEC_W), .REC_W(REC_W), .TX_ERR_INC(TX_ERR_INC), .REC_MAX(REC_MAX)
  ) u_counters (
    .clk(clk), .rst_n(rst_n), .freeze(in_busoff), .clear(recover_clr),
    .tx_err(tx_err_i), .rx_err(rx_err_i), .tx_ok(tx_ok_i), .rx_ok(rx_ok_i),
    .tec_q(tec_q), .rec_q(rec_q)
  );

  fc_recovery #(.RECOVER_RUNS(RECOVER_RUNS)) u_recovery (
    .clk(clk), .rst_n(rst_n), .in_busoff(in_busoff),
    .run_i(recessive_run_i), .clear_o(recover_clr)
  );

  fc_suspend #(.SUSPEND_BITS(SUSPEND_BITS)) u_suspend (
    .clk(clk), .rst_n(rst_n), .in_busoff(in_busoff), .arm(suspend_arm),
    .ifs_end(ifs_end_i), .bit_tick(bit_tick_i), .suspend_o(suspend_o)
  );

  assign state_o         = st;
  assign flag_dominant_o = (st == FC_ACTIVE);
  assign tx_en_o         = !in_busoff;
  assign tec_o           = tec_q;
  assign rec_o           = rec_q;

  assert_busoff_from_tx_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_busoff) |-> $past(tx_err_i));

  assert_recover_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_busoff) |-> (tec_q == '0 && rec_q == '0 && $past(recessive_run_i)));

  assert_dominant_flag_low_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_dominant_o |-> (int'(tec_q) < PASSIVE_AT && int'(rec_q) < PASSIVE_AT));

  assert_leave_passive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FC_PASSIVE && !tx_err_i && !rx_err_i && !tx_ok_i && !rx_ok_i) |=> (st == FC_PASSIVE));

endmodule

// File: tb/can_fault_guard_test.sv
module can_fault_guard_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, run = 0, ifs = 0, tick = 0;
  logic [1:0] state;
  logic flag_dom, tx_en, susp;
  logic [8:0] tec;
  logic [7:0] rec;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit cmp_on = 0;

  // reference model state
  int m_tec = 0, m_rec = 0, m_run = 0, m_cnt = 0;
  bit m_pend = 0, m_act = 0;

  always #10 clk = ~clk;

  can_fault_guard uut (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
    .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .recessive_run_i(run),
    .ifs_end_i(ifs), .bit_tick_i(tick), .state_o(state),
    .flag_dominant_o(flag_dom), .tx_en_o(tx_en), .suspend_o(susp),
    .tec_o(tec), .rec_o(rec)
  );

  function automatic int m_state(int t, int r);
    if (t >= 256) return 2;
    if (t >= 128 || r >= 128) return 1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int old_st;
    bit started;
    cycles++;
    if (!rst_n) begin
      m_tec = 0; m_rec = 0; m_run = 0; m_cnt = 0; m_pend = 0; m_act = 0;
    end else begin
      old_st = m_state(m_tec, m_rec);
      if (old_st == 2) begin
        m_pend = 0; m_act = 0; m_cnt = 0;
        if (run) begin
          m_run++;
          if (m_run == 128) begin m_tec = 0; m_rec = 0; m_run = 0; end
        end
      end else begin
        m_run = 0;
        if (tx_err) m_tec += 8;
        if (tx_ok && m_tec > 0) m_tec -= 1;
        m_rec = m_rec + int'(rx_err) - int'(rx_ok);
        if (m_rec < 0) m_rec = 0;
        if (m_rec > 255) m_rec = 255;
        started = 0;
        if (m_act) begin
          if (tick) begin
            m_cnt++;
            if (m_cnt == 8) begin m_act = 0; m_cnt = 0; end
          end
        end else if (m_pend && ifs) begin
          m_act = 1; m_cnt = 0; started = 1;
        end
        if (tx_ok && old_st == 1) m_pend = 1;
        else if (started) m_pend = 0;
      end
    end
    if (cycles >= 200000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 tec", int'(tec), m_tec);
      check("R3 rec", int'(rec), m_rec);
      check("R4/R5 state", int'(state), m_state(m_tec, m_rec));
      check("R6 flag", int'(flag_dom), int'(m_state(m_tec, m_rec) == 0));
      check("R7 tx_en", int'(tx_en), int'(m_state(m_tec, m_rec) != 2));
      check("R9 suspend", int'(susp), int'(m_act));
    end
  end

  task automatic drive(logic te, logic re, logic to, logic ro, logic rn, logic ie, logic tk);
    @(negedge clk);
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; run = rn; ifs = ie; tick = tk;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 tec", int'(tec), 0);
    check("R1 rec", int'(rec), 0);
    check("R1 state", int'(state), 0);
    check("R1 flag", int'(flag_dom), 1);
    check("R1 tx_en", int'(tx_en), 1);
    check("R1 suspend", int'(susp), 0);

    // R2 floor at zero
    drive(0, 0, 1, 0, 0, 0, 0); idle();
    check("R2 floor", int'(tec), 0);

    // R10 one-cycle latency
    drive(1, 0, 0, 0, 0, 0, 0); idle();
    check("R10 latency", int'(tec), 8);

    // R4 enter error-passive at 128
    for (int i = 0; i < 15; i++) drive(1, 0, 0, 0, 0, 0, 0);
    idle();
    check("R4 passive tec", int'(tec), 128);
    check("R4 passive", int'(state), 1);
    check("R6 recessive flag", int'(flag_dom), 0);

    // R9 suspend after passive transmission
    drive(0, 0, 1, 0, 0, 0, 0); idle();
    check("R4 back active", int'(state), 0);
    drive(0, 0, 0, 0, 0, 1, 0); idle();
    check("R9 suspend rises", int'(susp), 1);
    for (int i = 0; i < 7; i++) drive(0, 0, 0, 0, 0, 0, 1);
    idle();
    check("R9 still suspended", int'(susp), 1);
    drive(0, 0, 0, 0, 0, 0, 1); idle();
    check("R9 suspend ends", int'(susp), 0);

    // R5 receive count saturates, no bus-off
    for (int i = 0; i < 300; i++) drive(0, 1, 0, 0, 0, 0, 0);
    idle();
    check("R3 saturate", int'(rec), 255);
    check("R5 rec no busoff", int'(state), 1);

    // R2 simultaneous error and success
    drive(1, 0, 1, 0, 0, 0, 0); idle();
    check("R2 combined", int'(tec), 134);
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 1, 0, 0, 0);
    idle();
    check("R3 decrement", int'(rec), 245);

    // R5 bus-off
    for (int i = 0; i < 16; i++) drive(1, 0, 0, 0, 0, 0, 0);
    idle();
    check("R5 busoff", int'(state), 2);
    check("R7 tx_en off", int'(tx_en), 0);

    // R7 events ignored while bus-off
    drive(1, 1, 1, 1, 0, 1, 1); idle();
    check("R7 tec held", int'(tec), 262);
    check("R7 rec held", int'(rec), 245);

    // R8 recovery after 128 recessive runs
    for (int i = 0; i < 127; i++) begin drive(0, 0, 0, 0, 1, 0, 0); idle(); end
    check("R8 not yet", int'(state), 2);
    drive(0, 0, 0, 0, 1, 0, 0); idle();
    check("R8 recovered", int'(state), 0);
    check("R8 tec clear", int'(tec), 0);
    check("R8 rec clear", int'(rec), 0);

    repeat (4) idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule